// File: doc/BRIEF.md
# Programmable Event Timer Channel

This block is one channel of an event timer. It counts down on a tick-enable strobe, which normally pulses once per microsecond. When the programmed interval runs out, it raises a sticky level interrupt. Software sets the channel up through two 32-bit words that sit in an 8-byte window. The control word holds an enable flag, a mode flag and a 29-bit preset. The status word returns the live count and the pending flag, and a write to the status word clears the interrupt.

The preset is encoded as interval minus one: a preset of N expires on the (N+1)-th tick. In single-shot mode the channel disarms itself at expiry and holds its count at zero. In repeating mode it reloads the preset at every expiry and keeps running.

Writing a control word with the enable flag set reloads the counter at once. Writing zero stops the channel.

Top module: `evt_timer`

## Requirements
- R1: After reset, the interrupt is low and both words read 0.
- R2: The control word is at byte offset 0. Bit 31 is enable, bit 30 selects repeating mode, bit 29 is a spare bit that is stored and read back with no effect, and bits [28:0] hold the preset. A write whose two low address bits are not zero is ignored.
- R3: With preset N and enable set, the interrupt rises on the (N+1)-th tick strobe after the write. Cycles with the tick strobe low do not count. Preset 0 gives a one-tick interval.
- R4: In single-shot mode (bit 30 = 0), expiry clears the enable flag and the count stays at 0. Further ticks raise nothing new.
- R5: In repeating mode (bit 30 = 1), expiry reloads the preset. The channel stays enabled and expires again every N+1 ticks.
- R6: A control write with enable set loads the count from the new preset on the write edge, even while a count is in progress.
- R7: A control write with enable clear (for example, all zeros) stops the channel. The count is then frozen and no interrupt is raised.
- R8: The status word is at byte offset 4 and reads the count in bits [28:0] and the pending flag in bit 30, with all other bits 0.
- R9: Writing the status word with bit 30 = 1 clears the pending interrupt. Writing it with bit 30 = 0 has no effect. A status write never changes the control word or the count.
- R10: If an expiry and a clear fall on the same edge, the interrupt is left set.
- R11: The full preset 0x1FFFFFFF loads and counts down to 0x1FFFFFFE after one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle count strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Byte address inside the channel window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Sticky level interrupt |

## Verification
A control or status write takes effect on the edge that samples it, so the read-back and the interrupt line are checked at the falling edge that follows. An expiry is the tick edge that finds the count at zero, and the interrupt flop shows it one edge later, at the next falling edge. The bench therefore drives every input at a falling edge, applies exactly the required number of tick edges, and samples at the next falling edge. Reads are combinational, so each read sets the address and samples shortly after, with no clock in between.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int DATA_W   = 32;
    localparam int PRESET_W = 29;
    localparam int EN_BIT   = 31;
    localparam int MODE_BIT = 30;
    localparam int SPARE_BIT = 29;
    localparam int PEND_BIT = 30;
    localparam int SEL_BIT  = 2;

    typedef logic [PRESET_W-1:0] count_t;
    typedef logic [DATA_W-1:0]   word_t;

    typedef enum logic {
        WIN_CTRL = 1'b0,
        WIN_STAT = 1'b1
    } win_e;

    typedef struct packed {
        logic   arm;
        logic   repeat_mode;
        logic   spare;
        count_t preset;
    } ctrl_t;

    typedef struct packed {
        logic  load;
        ctrl_t value;
        logic  clear;
    } bus_cmd_t;

    function automatic ctrl_t unpack_ctrl(input word_t w);
        ctrl_t c;
        c.arm         = w[EN_BIT];
        c.repeat_mode = w[MODE_BIT];
        c.spare       = w[SPARE_BIT];
        c.preset      = w[PRESET_W-1:0];
        return c;
    endfunction

    function automatic word_t pack_ctrl(input ctrl_t c);
        word_t w;
        w = '0;
        w[EN_BIT]         = c.arm;
        w[MODE_BIT]       = c.repeat_mode;
        w[SPARE_BIT]      = c.spare;
        w[PRESET_W-1:0]   = c.preset;
        return w;
    endfunction

    function automatic word_t pack_stat(input count_t cnt, input logic pend);
        word_t w;
        w = '0;
        w[PRESET_W-1:0] = cnt;
        w[PEND_BIT]     = pend;
        return w;
    endfunction

endpackage

// File: rtl/evt_timer_bus.sv
module evt_timer_bus
    import evt_timer_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    input  ctrl_t             ctrl_q,
    input  count_t            count,
    input  logic              pend,
    output bus_cmd_t          cmd,
    output word_t             rdata
);

    localparam int ALIGN_W = SEL_BIT;

    logic aligned;
    win_e win;

    assign aligned = (addr[ALIGN_W-1:0] == '0);
    assign win     = win_e'(addr[SEL_BIT]);

    always_comb begin
        cmd.load  = wr && aligned && (win == WIN_CTRL);
        cmd.clear = wr && aligned && (win == WIN_STAT) && wdata[PEND_BIT];
        cmd.value = unpack_ctrl(wdata);
    end

    always_comb begin
        unique case (win)
            WIN_CTRL: rdata = pack_ctrl(ctrl_q);
            WIN_STAT: rdata = pack_stat(count, pend);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/evt_timer_count.sv
module evt_timer_count
    import evt_timer_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick_en,
    input  logic   load,
    input  ctrl_t  load_value,
    output ctrl_t  ctrl_q,
    output count_t count,
    output logic   expire
);

    logic at_zero;

    assign at_zero = (count == '0);
    assign expire  = ctrl_q.arm && tick_en && at_zero && !load;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            count  <= '0;
        end else if (load) begin
            ctrl_q <= load_value;
            if (load_value.arm) begin
                count <= load_value.preset;
            end
        end else if (ctrl_q.arm && tick_en) begin
            if (at_zero) begin
                if (ctrl_q.repeat_mode) begin
                    count <= ctrl_q.preset;
                end else begin
                    ctrl_q.arm <= 1'b0;
                end
            end else begin
                count <= count - 1'b1;
            end
        end
    end

    // R4
    a_r4_oneshot_halt: assert property (@(posedge clk) disable iff (rst)
        (expire && !ctrl_q.repeat_mode) |=> (!ctrl_q.arm && count == '0));

    // R5
    a_r5_periodic_reload: assert property (@(posedge clk) disable iff (rst)
        (expire && ctrl_q.repeat_mode) |=> (ctrl_q.arm && count == $past(ctrl_q.preset)));

    // R6
    a_r6_write_load: assert property (@(posedge clk) disable iff (rst)
        (load && load_value.arm) |=> (count == $past(load_value.preset)));

    // R7
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.arm && !load) |=> $stable(count));

endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (set) begin
            pend <= 1'b1;
        end else if (clr) begin
            pend <= 1'b0;
        end
    end

    // R10
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        set |=> pend);

    // R9
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !pend);

    // R9
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        (!set && !clr) |=> $stable(pend));

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    bus_cmd_t cmd;
    ctrl_t    ctrl_q;
    count_t   count;
    logic     expire;
    logic     pend;

    evt_timer_bus #(.ADDR_W(ADDR_W)) u_bus (
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .ctrl_q (ctrl_q),
        .count  (count),
        .pend   (pend),
        .cmd    (cmd),
        .rdata  (bus_rdata)
    );

    evt_timer_count u_count (
        .clk        (clk),
        .rst        (rst),
        .tick_en    (tick_en),
        .load       (cmd.load),
        .load_value (cmd.value),
        .ctrl_q     (ctrl_q),
        .count      (count),
        .expire     (expire)
    );

    evt_timer_irq u_irq (
        .clk  (clk),
        .rst  (rst),
        .set  (expire),
        .clr  (cmd.clear),
        .pend (pend)
    );

    assign irq = pend;

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!irq && ctrl_q == '0 && count == '0));

endmodule

// File: tb/evt_timer_tb.sv
module evt_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    evt_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd(3'd0, v); chk("R1 ctrl", v, 32'h0);
        rd(3'd4, v); chk("R1 stat", v, 32'h0);
    endtask

    task automatic t_fields();
        logic [31:0] v;
        wr(3'd0, 32'hBFFF_FFFF);
        rd(3'd0, v); chk("R2 ctrl readback", v, 32'hBFFF_FFFF);
        rd(3'd4, v); chk("R11 max preset loaded", v, 32'h1FFF_FFFF);
        ticks(1);
        rd(3'd4, v); chk("R11 max preset decrement", v, 32'h1FFF_FFFE);
        wr(3'd1, 32'h0);
        rd(3'd0, v); chk("R2 unaligned write ignored", v, 32'hBFFF_FFFF);
        wr(3'd0, 32'h0);
        rd(3'd0, v); chk("R7 stop clears ctrl", v, 32'h0);
        ticks(4);
        rd(3'd4, v); chk("R7 count frozen", v, 32'h1FFF_FFFE);
        chk("R7 no irq when stopped", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        wr(3'd0, 32'h8000_0004);
        ticks(4);
        rd(3'd4, v); chk("R3 count at zero before expiry", v, 32'h0);
        chk("R3 no irq after N ticks", {31'b0, irq}, 32'h0);
        repeat (5) @(negedge clk);
        chk("R3 idle cycles do not count", {31'b0, irq}, 32'h0);
        ticks(1);
        chk("R3 irq after N+1 ticks", {31'b0, irq}, 32'h1);
        rd(3'd0, v); chk("R4 enable cleared", v, 32'h0000_0004);
        rd(3'd4, v); chk("R8 status pending and count", v, 32'h4000_0000);
        ticks(6);
        rd(3'd4, v); chk("R4 count held at zero", v, 32'h4000_0000);
        wr(3'd4, 32'h4000_0000);
        chk("R9 clear", {31'b0, irq}, 32'h0);
        ticks(3);
        chk("R4 no further irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_min();
        wr(3'd0, 32'h8000_0000);
        ticks(1);
        chk("R3 preset zero one tick", {31'b0, irq}, 32'h1);
        wr(3'd4, 32'h4000_0000);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        wr(3'd0, 32'hC000_0002);
        ticks(3);
        chk("R5 first expiry", {31'b0, irq}, 32'h1);
        rd(3'd4, v); chk("R5 reloaded", v, 32'h4000_0002);
        rd(3'd0, v); chk("R5 stays enabled", v, 32'hC000_0002);
        wr(3'd4, 32'h4000_0000);
        ticks(2);
        chk("R5 no early irq", {31'b0, irq}, 32'h0);
        ticks(1);
        chk("R5 second expiry", {31'b0, irq}, 32'h1);
        wr(3'd0, 32'h0);
        wr(3'd4, 32'h4000_0000);
    endtask

    task automatic t_reload();
        logic [31:0] v;
        wr(3'd0, 32'h8000_000A);
        ticks(3);
        rd(3'd4, v); chk("R6 counting", v, 32'h0000_0007);
        wr(3'd0, 32'h8000_0005);
        rd(3'd4, v); chk("R6 reload mid-count", v, 32'h0000_0005);
        ticks(5);
        chk("R6 no irq before new interval", {31'b0, irq}, 32'h0);
        ticks(1);
        chk("R6 irq at new interval", {31'b0, irq}, 32'h1);
        wr(3'd4, 32'h4000_0000);
    endtask

    task automatic t_clear_rules();
        logic [31:0] v;
        wr(3'd0, 32'h8000_0000);
        ticks(1);
        wr(3'd4, 32'hBFFF_FFFF);
        chk("R9 bit30 zero no clear", {31'b0, irq}, 32'h1);
        rd(3'd0, v); chk("R9 ctrl untouched", v, 32'h0);
        wr(3'd0, 32'h8000_0003);
        ticks(1);
        wr(3'd4, 32'h4000_0000);
        chk("R9 clear works", {31'b0, irq}, 32'h0);
        rd(3'd4, v); chk("R9 count untouched", v, 32'h0000_0002);
        wr(3'd0, 32'h0);
    endtask

    task automatic t_set_wins();
        wr(3'd0, 32'h8000_0000);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 32'h4000_0000; tick_en = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
        chk("R10 set wins over clear", {31'b0, irq}, 32'h1);
        wr(3'd4, 32'h4000_0000);
        chk("R10 later clear", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fields();
        t_oneshot();
        t_min();
        t_periodic();
        t_reload();
        t_clear_rules();
        t_set_wins();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule